// File: doc/BRIEF.md
# Phase Detector with Lock Detect

This block compares two single-cycle pulse trains, both synchronous to the oscillator clock. One is the reference train and the other comes from the feedback divider. A leading reference pulse asks the loop to speed up, and a leading divider pulse asks it to slow down. The block turns that phase difference into a three-state charge-pump command: drive high, drive low, or release (high-Z). It also produces a pair of comparator pulse outputs for an external pump, a lock indicator and a selectable monitor output.

Phase error is the number of clock cycles between the two edges of one comparison. The lock indicator uses that count with hysteresis. It falls as soon as one comparison reaches the unlock threshold. It rises only after a run of consecutive comparisons that each stay within the lock tolerance.

A polarity input swaps every detector output and picks which pulse train appears on the monitor. A pump-enable input can release the pump at any time. A power-on input puts the block into a low-power hold that clears the detector and forces the lock indicator high. After reset or on leaving the hold, the pump drive of the first comparison is cut short so the loop is not disturbed by a large start-up pulse.

Top module: `phase_lock_det`

## Requirements
- R1: After reset with `pwr_on` high, `cp_oe` is 0, `cmp_r` and `cmp_p` are 0 and `lock` is 0.
- R2: When one pulse leads the other by D cycles (D ≥ 1), `cp_oe` is 1 for exactly D cycles, starting the cycle after the leading pulse is sampled. With `pol`=1, `cp_lvl` is 1 when the reference leads and 0 when the divider leads; with `pol`=0 these levels are swapped. `cp_lvl` is 0 whenever `cp_oe` is 0.
- R3: With `pol`=1, `cmp_r` follows the reference-side latch and `cmp_p` the divider-side latch; with `pol`=0 they swap. Each latch sets on its pulse and holds until both are set. Both are then high together for exactly one cycle and clear on the next. During that cycle, and for coincident pulses, `cp_oe` is 0.
- R4: With `mon_sel`=1, `mon` equals `ref_pls` when `pol`=1 and `div_pls` when `pol`=0. With `mon_sel`=0, `mon` equals `lock`.
- R5: A comparison whose error reaches UNLOCK_CYC (default 3) cycles clears `lock` and restarts the count of good comparisons.
- R6: `lock` rises only at the end of a comparison that completes a run of LOCK_CNT (default 3) consecutive comparisons, each with an error of at most LOCK_ERR (default 2) cycles. A comparison whose error lies between LOCK_ERR and UNLOCK_CYC restarts the run but leaves `lock` unchanged.
- R7: `cp_en`=0 keeps `cp_oe` at 0, while the comparator outputs and the lock logic keep running.
- R8: `pwr_on`=0 holds `cp_oe`, `cmp_r` and `cmp_p` at 0, ignores both pulse inputs and makes `lock` 1. When `pwr_on` returns, `lock` stays 1 until a large error occurs.
- R9: For the first comparison after reset or after `pwr_on` returns high, the pump drives for at most WAKE_CYC (default 2) cycles, whatever the phase error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pls | input | 1 | Reference pulse, one cycle wide |
| div_pls | input | 1 | Divided feedback pulse, one cycle wide |
| pol | input | 1 | Detector polarity |
| mon_sel | input | 1 | Monitor source: 1 pulse train, 0 lock |
| cp_en | input | 1 | Pump enable, 0 forces release |
| pwr_on | input | 1 | 1 normal, 0 low-power hold |
| cp_oe | output | 1 | Pump drives when 1, high-Z when 0 |
| cp_lvl | output | 1 | Pump drive level |
| cmp_r | output | 1 | Reference-side comparator output |
| cmp_p | output | 1 | Divider-side comparator output |
| lock | output | 1 | Lock indicator |
| mon | output | 1 | Monitor output |

## Verification
The hardest state to reach is a lock rise that depends on history. Reaching it takes an unbroken run of small-error comparisons that no medium or large error interrupts. It must also follow either a power-save exit, where lock is already high, or an earlier drop. The stimulus mixes directed sequences, which build a run, break it and rebuild it, with random signed offsets biased toward small errors and occasional power-save episodes. The wake-up truncation is reached directly by following a power-save exit with a large offset.

// File: rtl/phase_lock_det.sv
module phase_lock_det #(
  parameter int UNLOCK_CYC = 3,
  parameter int LOCK_ERR   = 2,
  parameter int LOCK_CNT   = 3,
  parameter int WAKE_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pls,
  input  logic div_pls,
  input  logic pol,
  input  logic mon_sel,
  input  logic cp_en,
  input  logic pwr_on,
  output logic cp_oe,
  output logic cp_lvl,
  output logic cmp_r,
  output logic cmp_p,
  output logic lock,
  output logic mon
);
  localparam int EW = $clog2(UNLOCK_CYC + 1);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic          up_q, dn_q, align_q, lock_q;
  logic [EW-1:0] err_q;
  logic [GW-1:0] good_q;

  wire match = up_q & dn_q;
  wire lead  = up_q ^ dn_q;

  wire [EW-1:0] err_inc  = (err_q == EW'(UNLOCK_CYC)) ? err_q : err_q + 1'b1;
  wire [GW-1:0] good_inc = (good_q == GW'(LOCK_CNT)) ? good_q : good_q + 1'b1;

  wire big_now   = lead && (err_inc >= EW'(UNLOCK_CYC));
  wire big_end   = match && (err_q >= EW'(UNLOCK_CYC));
  wire small_end = match && (err_q <= EW'(LOCK_ERR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_q   <= '0;
      good_q  <= '0;
      lock_q  <= 1'b0;
      align_q <= 1'b1;
    end else if (!pwr_on) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_q   <= '0;
      good_q  <= '0;
      lock_q  <= 1'b1;
      align_q <= 1'b1;
    end else begin
      up_q  <= match ? ref_pls : (up_q | ref_pls);
      dn_q  <= match ? div_pls : (dn_q | div_pls);
      err_q <= match ? '0 : (lead ? err_inc : err_q);
      if (match) align_q <= 1'b0;
      if (big_now || big_end) begin
        lock_q <= 1'b0;
        good_q <= '0;
      end else if (small_end) begin
        good_q <= good_inc;
        if (good_inc >= GW'(LOCK_CNT)) lock_q <= 1'b1;
      end else if (match) begin
        good_q <= '0;
      end
    end
  end

  wire drive = lead && cp_en && pwr_on && !(align_q && (err_q >= EW'(WAKE_CYC)));

  assign cp_oe  = drive;
  assign cp_lvl = drive & (pol ? up_q : dn_q);
  assign cmp_r  = pol ? up_q : dn_q;
  assign cmp_p  = pol ? dn_q : up_q;
  assign lock   = lock_q | ~pwr_on;
  assign mon    = mon_sel ? (pol ? ref_pls : div_pls) : lock;

  // R3
  pfd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ref_pls && !div_pls) |=> (!up_q && !dn_q));

  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= EW'(UNLOCK_CYC));

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_q) && $past(pwr_on)) |-> $past(up_q && dn_q));

  // R8
  ps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!up_q && !dn_q && lock_q));

  // R2
  drive_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_oe |-> (cmp_r != cmp_p));
endmodule

// File: tb/tb_phase_lock_det.sv
module tb_phase_lock_det;
  localparam int UNL = 3, LE = 2, LC = 3, WK = 2;

  logic clk = 0, rst_n = 0;
  logic ref_pls = 0, div_pls = 0, pol = 1, mon_sel = 0, cp_en = 1, pwr_on = 1;
  logic cp_oe, cp_lvl, cmp_r, cmp_p, lock, mon;

  int checks = 0, fails = 0;
  int m_lock = 0, m_good = 0, m_align = 1;

  phase_lock_det #(.UNLOCK_CYC(UNL), .LOCK_ERR(LE), .LOCK_CNT(LC), .WAKE_CYC(WK)) dut (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .div_pls(div_pls), .pol(pol),
    .mon_sel(mon_sel), .cp_en(cp_en), .pwr_on(pwr_on), .cp_oe(cp_oe), .cp_lvl(cp_lvl),
    .cmp_r(cmp_r), .cmp_p(cmp_p), .lock(lock), .mon(mon));

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_lock(int ld);
    if (ld >= UNL) begin m_good = 0; return 0; end
    if (ld <= LE) begin
      if (m_good < LC) m_good++;
      return (m_good >= LC) ? 1 : m_lock;
    end
    m_good = 0;
    return m_lock;
  endfunction

  task automatic pair(int d);
    int ld = (d < 0) ? -d : d;
    string tag;
    for (int c = 0; c <= ld + 3; c++) begin
      @(negedge clk);
      ref_pls = (d >= 0) ? (c == 0) : (c == ld);
      div_pls = (d >= 0) ? (c == ld) : (c == 0);
      #1;
      if (mon_sel) chk("R4 mon pulse", mon, pol ? ref_pls : div_pls);
      if (c >= 1) begin
        int k = c - 1;
        int up_e, dn_e, drv, lvl;
        up_e = (d >= 0) ? (k <= ld) : (k == ld);
        dn_e = (d >= 0) ? (k == ld) : (k <= ld);
        if (!pwr_on) begin up_e = 0; dn_e = 0; end
        drv = (pwr_on && cp_en && k < ld && !(m_align && k >= WK)) ? 1 : 0;
        lvl = drv ? (pol ? up_e : dn_e) : 0;
        if (!pwr_on) tag = "R8 cp_oe";
        else if (!cp_en) tag = "R7 cp_oe";
        else if (m_align && ld > WK) tag = "R9 cp_oe";
        else if (ld == 0) tag = "R3 cp_oe";
        else tag = "R2 cp_oe";
        chk(tag, cp_oe, drv);
        chk("R2 cp_lvl", cp_lvl, lvl);
        chk("R3 cmp_r", cmp_r, pol ? up_e : dn_e);
        chk("R3 cmp_p", cmp_p, pol ? dn_e : up_e);
      end
    end
    ref_pls = 0; div_pls = 0;
    if (pwr_on) begin
      m_align = 0;
      m_lock = next_lock(ld);
    end
    @(negedge clk); #1;
    if (!pwr_on) chk("R8 lock", lock, 1);
    else chk((ld >= UNL) ? "R5 lock" : "R6 lock", lock, m_lock);
    if (!mon_sel) chk("R4 mon lock", mon, lock);
  endtask

  task automatic set_ps(logic v);
    @(negedge clk);
    pwr_on = v;
    if (!v) begin m_lock = 1; m_good = 0; m_align = 1; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    checks++; fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 cp_oe", cp_oe, 0);
    chk("R1 cmp_r", cmp_r, 0);
    chk("R1 cmp_p", cmp_p, 0);
    chk("R1 lock", lock, 0);
    // R9: first comparison after reset truncated
    pair(4);
    // R6: three small comparisons in a row
    pair(2); pair(-2); pair(0);
    // R5: single large error drops lock
    pair(-3);
    // R6: run broken and rebuilt
    pair(1); pair(1); pair(5); pair(1); pair(-1); pair(2);
    pol = 0; pair(1); pair(-2);
    mon_sel = 1; pair(2); pol = 1; pair(-1); mon_sel = 0;
    // R7
    cp_en = 0; pair(2); pair(-4); cp_en = 1;
    // R8 then R9
    set_ps(0); pair(3); pair(-1); set_ps(1);
    pair(-5); pair(1);
    for (int i = 0; i < 400; i++) begin
      int d = int'($urandom_range(0, 12)) - 6;
      if ($urandom_range(0, 2) != 0) d = int'($urandom_range(0, 4)) - 2;
      pol     = $urandom_range(0, 1) == 1;
      mon_sel = $urandom_range(0, 1) == 1;
      cp_en   = $urandom_range(0, 7) != 0;
      if ($urandom_range(0, 19) == 0) begin
        set_ps(0); pair(d); set_ps(1);
      end else begin
        pair(d);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule